// File: doc/BRIEF.md
# Exception Priority Arbiter with Lockup

This block chooses which pending exception a processor core should enter next and whether that exception may interrupt the handler that is running. Requests come from a non-maskable line, a hard-fault line and a vector of external interrupt lines. Each external line carries its own programmable priority. The block latches every request as pending. Each cycle it selects one winner among the pending requests. When the winner is more urgent than the handler that is currently active, the block emits a one-cycle entry strobe. It then records the new handler as active and saves the interrupted one on a small nesting stack. A return strobe from the core restores the saved handler.

The block also tracks a lockup condition. Lockup starts when a bus error hits the non-maskable or hard-fault handler, or when a bus error occurs while an exception return unstacks from the main stack. While locked, nothing is entered and returns are ignored. Lockup ends on a debugger clear strobe or on reset. A non-maskable request also ends it, but only when the lockup began inside the hard-fault handler. Instruction execution, stacking and vector fetch belong to the core and are outside this block.

Top module: `exc_arbiter`

## Requirements
- R1: After reset `take` and `lockup` are 0, `act_num` is 0 and `act_level` is the idle level 2^PRIO_W+2 (6 by default). A reset also discards every pending request.
- R2: Exception numbers are fixed: non-maskable is 2, hard fault is 3 and external line i is 16+i. Urgency levels are also fixed: non-maskable is 0, hard fault is 1, and line i is 2 plus its priority field `irq_prio[i*PRIO_W +: PRIO_W]`.
- R3: Among pending requests the one with the lowest level wins. When levels are equal, the lower exception number wins.
- R4: A winner is entered only if its level is strictly below `act_level`. A pending request that is not more urgent stays pending until the active level rises above it.
- R5: A request that is captured at a clock edge can be decided in the following cycle. `take` is high for exactly one cycle per entry, in the cycle after the decision, and `take_num` gives the entered number. Entry clears that request's pending bit, so each request produces a single entry.
- R6: While the non-maskable handler is active, no request causes an entry. A further non-maskable request stays pending.
- R7: While the hard-fault handler is active, only a non-maskable request causes an entry. New hard-fault and external requests stay pending.
- R8: `exc_ret` pops the nesting stack and restores the previous `act_num` and `act_level`. Pending work then competes against the restored level. A return with no active handler is ignored.
- R9: `bus_err` while handler 2 or 3 is active sets `lockup` after the next edge. `ret_bus_err` sets it in any context. `bus_err` in any other handler has no effect on `lockup`.
- R10: While `lockup` is 1, no entry happens, `exc_ret` is ignored and `act_num` holds.
- R11: `dbg_clr` always ends lockup. A pending non-maskable request ends lockup only when lockup was entered with handler 3 active, and the non-maskable handler is then entered.
- R12: If lockup was entered with handler 2 active, a further non-maskable request leaves `lockup` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request strobe |
| hf_req | input | 1 | Hard-fault request strobe |
| bus_err | input | 1 | Bus error strobe during handler execution |
| ret_bus_err | input | 1 | Bus error strobe while unstacking from the main stack on return |
| dbg_clr | input | 1 | Debugger strobe that ends lockup |
| exc_ret | input | 1 | Exception return strobe |
| irq_req | input | NUM_IRQ | External request strobes, one per line |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority field per line, line i at bits i*PRIO_W |
| take | output | 1 | One-cycle entry strobe |
| take_num | output | 9 | Number of the exception entered |
| act_num | output | 9 | Active exception number, 0 when idle |
| act_level | output | PRIO_W+2 | Urgency level of the active handler |
| lockup | output | 1 | Lockup flag |

## Verification
The assertions check several rules on every cycle. Nothing but a return leaves the non-maskable handler, and the hard-fault handler yields only to the non-maskable one. Every entry strictly lowers the active level. Lockup suppresses entries and freezes the active number, and it holds against non-maskable requests when it began in the non-maskable handler. Other behaviour needs the bench's scenarios. These cover the tie-break order among equal priorities and the single entry per request. They also cover the restore order of nested returns, the re-entry of requests held back while a more urgent handler ran, and the asymmetric lockup exits. A final scenario shows that a reset drops pending work.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int EXC_W    = 9;
  localparam int NUM_NMI  = 2;
  localparam int NUM_HF   = 3;
  localparam int IRQ_BASE = 16;
  typedef logic [EXC_W-1:0] exc_num_t;
endpackage

// File: rtl/exc_pend.sv
module exc_pend #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_set,
  input  logic               hf_set,
  input  logic [NUM_IRQ-1:0] irq_set,
  input  logic               nmi_clr,
  input  logic               hf_clr,
  input  logic [NUM_IRQ-1:0] irq_clr,
  output logic               nmi_pend,
  output logic               hf_pend,
  output logic [NUM_IRQ-1:0] irq_pend
);
  logic               nmi_d, hf_d;
  logic [NUM_IRQ-1:0] irq_d;

  // a new request in the same cycle as its entry survives the clear
  always_comb begin
    nmi_d = (nmi_pend & ~nmi_clr) | nmi_set;
    hf_d  = (hf_pend  & ~hf_clr)  | hf_set;
    irq_d = (irq_pend & ~irq_clr) | irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend <= 1'b0;
      hf_pend  <= 1'b0;
      irq_pend <= '0;
    end else begin
      nmi_pend <= nmi_d;
      hf_pend  <= hf_d;
      irq_pend <= irq_d;
    end
  end
endmodule

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 2,
  localparam int LVL_W  = PRIO_W + 2
) (
  input  logic                      nmi_pend,
  input  logic                      hf_pend,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  output logic                      win_vld,
  output exc_num_t                  win_num,
  output logic [LVL_W-1:0]          win_lvl,
  output logic                      win_nmi,
  output logic                      win_hf,
  output logic [NUM_IRQ-1:0]        win_irq
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [LVL_W-1:0] src_lvl [NUM_IRQ];
  logic             best_vld;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_lvl;

  // configurable levels sit above the two fixed ones
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_lvl
    assign src_lvl[g] = LVL_W'(irq_prio[g*PRIO_W +: PRIO_W]) + LVL_W'(2);
  end

  // strict compare keeps the lowest index on a tie
  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    best_lvl = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (irq_pend[i] && (!best_vld || (src_lvl[i] < best_lvl))) begin
        best_vld = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = src_lvl[i];
      end
    end
  end

  always_comb begin
    win_nmi = nmi_pend;
    win_hf  = !nmi_pend && hf_pend;
    win_vld = nmi_pend || hf_pend || best_vld;
    if (nmi_pend) begin
      win_num = exc_num_t'(NUM_NMI);
      win_lvl = '0;
    end else if (hf_pend) begin
      win_num = exc_num_t'(NUM_HF);
      win_lvl = LVL_W'(1);
    end else begin
      win_num = exc_num_t'(IRQ_BASE) + exc_num_t'(best_idx);
      win_lvl = best_lvl;
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_win
    assign win_irq[g] = !nmi_pend && !hf_pend && best_vld && (best_idx == IDX_W'(g));
  end
endmodule

// File: rtl/exc_nest.sv
module exc_nest
  import exc_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int LVL_W    = 4,
  parameter int IDLE_LVL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  exc_num_t         push_num,
  input  logic [LVL_W-1:0] push_lvl,
  output exc_num_t         top_num,
  output logic [LVL_W-1:0] top_lvl
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  exc_num_t         num_mem [DEPTH];
  logic [LVL_W-1:0] lvl_mem [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_d, sp_m1;
  logic             do_push, do_pop;

  always_comb begin
    do_push = push && (sp_q < SP_W'(DEPTH));
    do_pop  = pop && !push && (sp_q != '0);
    sp_m1   = sp_q - SP_W'(1);
    sp_d    = sp_q;
    if (do_push)     sp_d = sp_q + SP_W'(1);
    else if (do_pop) sp_d = sp_m1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      num_mem[sp_q[IDX_W-1:0]] <= push_num;
      lvl_mem[sp_q[IDX_W-1:0]] <= push_lvl;
    end
  end

  always_comb begin
    if (sp_q == '0) begin
      top_num = '0;
      top_lvl = LVL_W'(IDLE_LVL);
    end else begin
      top_num = num_mem[sp_m1[IDX_W-1:0]];
      top_lvl = lvl_mem[sp_m1[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/exc_lock.sv
module exc_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_err,
  input  logic ret_bus_err,
  input  logic dbg_clr,
  input  logic nmi_pend,
  input  logic act_is_nmi,
  input  logic act_is_hf,
  output logic lock_q,
  output logic lock_enter
);
  logic from_hf_q, from_hf_d, lock_d, lock_exit;

  always_comb begin
    lock_enter = !lock_q && (ret_bus_err || (bus_err && (act_is_nmi || act_is_hf)));
    lock_exit  = lock_q && (dbg_clr || (nmi_pend && from_hf_q));
    lock_d     = lock_q;
    from_hf_d  = from_hf_q;
    if (lock_enter) begin
      lock_d    = 1'b1;
      from_hf_d = act_is_hf;
    end else if (lock_exit) begin
      lock_d    = 1'b0;
      from_hf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      from_hf_q <= 1'b0;
    end else begin
      lock_q    <= lock_d;
      from_hf_q <= from_hf_d;
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int PRIO_W   = 2,
  localparam int LVL_W   = PRIO_W + 2,
  localparam int IDLE_LVL = (1 << PRIO_W) + 2,
  localparam int DEPTH   = IDLE_LVL
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      nmi_req,
  input  logic                      hf_req,
  input  logic                      bus_err,
  input  logic                      ret_bus_err,
  input  logic                      dbg_clr,
  input  logic                      exc_ret,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  output logic                      take,
  output logic [EXC_W-1:0]          take_num,
  output logic [EXC_W-1:0]          act_num,
  output logic [LVL_W-1:0]          act_level,
  output logic                      lockup
);
  logic               nmi_pend, hf_pend;
  logic [NUM_IRQ-1:0] irq_pend, win_irq, irq_clr;
  logic               win_vld, win_nmi, win_hf;
  exc_num_t           win_num, top_num, act_num_d, take_num_d;
  logic [LVL_W-1:0]   win_lvl, top_lvl, act_lvl_d;
  logic               take_go, ret_go, lock_enter, take_d;

  exc_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .nmi_set(nmi_req), .hf_set(hf_req), .irq_set(irq_req),
    .nmi_clr(take_go && win_nmi), .hf_clr(take_go && win_hf), .irq_clr(irq_clr),
    .nmi_pend(nmi_pend), .hf_pend(hf_pend), .irq_pend(irq_pend)
  );

  exc_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_sel (
    .nmi_pend(nmi_pend), .hf_pend(hf_pend), .irq_pend(irq_pend), .irq_prio(irq_prio),
    .win_vld(win_vld), .win_num(win_num), .win_lvl(win_lvl),
    .win_nmi(win_nmi), .win_hf(win_hf), .win_irq(win_irq)
  );

  exc_nest #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IDLE_LVL(IDLE_LVL)) u_nest (
    .clk(clk), .rst_n(rst_n), .push(take_go), .pop(ret_go),
    .push_num(act_num), .push_lvl(act_level),
    .top_num(top_num), .top_lvl(top_lvl)
  );

  exc_lock u_lock (
    .clk(clk), .rst_n(rst_n), .bus_err(bus_err), .ret_bus_err(ret_bus_err),
    .dbg_clr(dbg_clr), .nmi_pend(nmi_pend),
    .act_is_nmi(act_num == exc_num_t'(NUM_NMI)),
    .act_is_hf(act_num == exc_num_t'(NUM_HF)),
    .lock_q(lockup), .lock_enter(lock_enter)
  );

  // decision: returns win over entries in the same cycle
  always_comb begin
    ret_go  = exc_ret && !lockup && !lock_enter && (act_num != '0);
    take_go = win_vld && (win_lvl < act_level) && !lockup && !lock_enter && !ret_go;
    irq_clr = take_go ? win_irq : '0;
    take_d     = take_go;
    take_num_d = take_go ? win_num : take_num;
    act_num_d  = act_num;
    act_lvl_d  = act_level;
    if (take_go) begin
      act_num_d = win_num;
      act_lvl_d = win_lvl;
    end else if (ret_go) begin
      act_num_d = top_num;
      act_lvl_d = top_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= 1'b0;
      take_num  <= '0;
      act_num   <= '0;
      act_level <= LVL_W'(IDLE_LVL);
    end else begin
      take      <= take_d;
      take_num  <= take_num_d;
      act_num   <= act_num_d;
      act_level <= act_lvl_d;
    end
  end
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
  import exc_pkg::*;
#(
  parameter int PRIO_W = 2,
  localparam int LVL_W = PRIO_W + 2,
  localparam int IDLE_LVL = (1 << PRIO_W) + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_ret,
  input logic             bus_err,
  input logic             dbg_clr,
  input logic             take,
  input logic [EXC_W-1:0] act_num,
  input logic [LVL_W-1:0] act_level,
  input logic             lockup
);
  localparam logic [EXC_W-1:0] N_NMI = EXC_W'(NUM_NMI);
  localparam logic [EXC_W-1:0] N_HF  = EXC_W'(NUM_HF);

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_num == '0) |-> (act_level == LVL_W'(IDLE_LVL)));

  // R4
  entry_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (act_level < $past(act_level)));

  // R6
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_num == N_NMI && !exc_ret) |=> (act_num == N_NMI));

  // R7
  hf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_num == N_HF && !exc_ret) |=> (act_num == N_HF || act_num == N_NMI));

  // R9
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockup && bus_err && (act_num == N_NMI || act_num == N_HF)) |=> lockup);

  // R10
  lock_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> !take);

  // R10
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> $stable(act_num));

  // R12
  nmi_lock_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockup && act_num == N_NMI && !dbg_clr) |=> lockup);
endmodule

bind exc_arbiter exc_arbiter_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_ret(exc_ret), .bus_err(bus_err), .dbg_clr(dbg_clr),
  .take(take), .act_num(act_num), .act_level(act_level), .lockup(lockup)
);

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
  import exc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int PW = 2;

  logic clk, rst_n, nmi_req, hf_req, bus_err, ret_bus_err, dbg_clr, exc_ret;
  logic [NI-1:0]    irq_req;
  logic [NI*PW-1:0] irq_prio;
  logic             take, lockup;
  logic [EXC_W-1:0] take_num, act_num;
  logic [PW+1:0]    act_level;

  int nvec = 0;
  int nmis = 0;
  int exp_q[$];

  exc_arbiter #(.NUM_IRQ(NI), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .hf_req(hf_req), .bus_err(bus_err),
    .ret_bus_err(ret_bus_err), .dbg_clr(dbg_clr), .exc_ret(exc_ret),
    .irq_req(irq_req), .irq_prio(irq_prio), .take(take), .take_num(take_num),
    .act_num(act_num), .act_level(act_level), .lockup(lockup)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nmis++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every entry strobe must match the next expected number (R5)
  always @(negedge clk) begin
    if (rst_n && take) begin
      if (exp_q.size() == 0) chk("R5 unexpected entry", int'(take_num), -1);
      else chk("R5 entry number", int'(take_num), exp_q.pop_front());
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 nmi, 1 hf, 2 bus_err, 3 ret_bus_err, 4 dbg_clr, 5 exc_ret, 6 irq mask
  task automatic pulse(input int what, input logic [NI-1:0] mask);
    @(negedge clk);
    case (what)
      0: nmi_req = 1'b1;
      1: hf_req = 1'b1;
      2: bus_err = 1'b1;
      3: ret_bus_err = 1'b1;
      4: dbg_clr = 1'b1;
      5: exc_ret = 1'b1;
      default: irq_req = mask;
    endcase
    @(negedge clk);
    {nmi_req, hf_req, bus_err, ret_bus_err, dbg_clr, exc_ret} = '0;
    irq_req = '0;
    settle(4);
  endtask

  task automatic act_is(input string req, input int num, input int lvl);
    chk({req, " act_num"}, int'(act_num), num);
    chk({req, " act_level"}, int'(act_level), lvl);
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    nmis++;
    $display("FAIL watchdog actual=%0d expected=0", wd);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {nmi_req, hf_req, bus_err, ret_bus_err, dbg_clr, exc_ret} = '0;
    irq_req = '0;
    // R2 priority fields: line0=1 line1=2 line2=1 line3=0 others=3
    irq_prio = {2'd3, 2'd3, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd1};
    settle(3);
    rst_n = 1'b1;
    settle(2);
    // R1
    act_is("R1", 0, 6);
    chk("R1 take", int'(take), 0);
    chk("R1 lockup", int'(lockup), 0);

    // R2 R4 line1 enters from idle
    exp_q.push_back(17);
    pulse(6, 8'h02);
    act_is("R2", 17, 4);
    // R4 line4 (level 5) cannot preempt level 4
    pulse(6, 8'h10);
    act_is("R4", 17, 4);
    // R9 bus error in an external handler is ignored
    pulse(2, '0);
    chk("R9 no lockup", int'(lockup), 0);
    // R3 lines 0 and 2 tie at level 3, lower number wins
    exp_q.push_back(16);
    pulse(6, 8'h05);
    act_is("R3", 16, 3);
    // R8 return to 17, then pending line2 enters
    exp_q.push_back(18);
    pulse(5, '0);
    act_is("R8", 18, 3);
    pulse(5, '0);
    act_is("R8 restore", 17, 4);
    exp_q.push_back(20);
    pulse(5, '0);
    act_is("R4 held entry", 20, 5);
    pulse(5, '0);
    act_is("R8 idle", 0, 6);
    pulse(5, '0);
    act_is("R8 idle return ignored", 0, 6);

    // R7 hard fault handler
    exp_q.push_back(3);
    pulse(1, '0);
    act_is("R7", 3, 1);
    pulse(1, '0);
    pulse(6, 8'h08);
    act_is("R7 held", 3, 1);
    exp_q.push_back(2);
    pulse(0, '0);
    act_is("R7 nmi preempts", 2, 0);
    // R6
    pulse(0, '0);
    act_is("R6", 2, 0);
    exp_q.push_back(2);
    pulse(5, '0);
    act_is("R6 reentry", 2, 0);
    pulse(5, '0);
    act_is("R8 back to hf", 3, 1);
    exp_q.push_back(3);
    pulse(5, '0);
    act_is("R3 hf before line3", 3, 1);
    exp_q.push_back(19);
    pulse(5, '0);
    act_is("R3 line3", 19, 2);
    pulse(5, '0);
    act_is("R8 idle again", 0, 6);

    // lockup from hard fault
    exp_q.push_back(3);
    pulse(1, '0);
    pulse(2, '0);
    chk("R9 lockup in hf", int'(lockup), 1);
    pulse(6, 8'h08);
    pulse(5, '0);
    act_is("R10 frozen", 3, 1);
    chk("R10 still locked", int'(lockup), 1);
    exp_q.push_back(2);
    pulse(0, '0);
    chk("R11 nmi exit", int'(lockup), 0);
    act_is("R11 nmi entered", 2, 0);
    pulse(5, '0);
    exp_q.push_back(19);
    pulse(5, '0);
    act_is("R10 held line3", 19, 2);
    pulse(5, '0);
    act_is("R10 idle", 0, 6);

    // lockup from nmi
    exp_q.push_back(2);
    pulse(0, '0);
    pulse(2, '0);
    chk("R9 lockup in nmi", int'(lockup), 1);
    pulse(0, '0);
    chk("R12 nmi no release", int'(lockup), 1);
    pulse(4, '0);
    chk("R11 dbg clear", int'(lockup), 0);
    act_is("R11 nmi still active", 2, 0);
    exp_q.push_back(2);
    pulse(5, '0);
    act_is("R6 pending nmi after return", 2, 0);
    pulse(5, '0);

    // unstack error
    pulse(3, '0);
    chk("R9 ret bus error", int'(lockup), 1);
    pulse(0, '0);
    chk("R11 nmi no release outside hf", int'(lockup), 1);
    exp_q.push_back(2);
    pulse(4, '0);
    chk("R11 dbg clear idle", int'(lockup), 0);
    act_is("R11 nmi after clear", 2, 0);
    pulse(5, '0);

    // R1 reset drops pending work
    exp_q.push_back(3);
    pulse(1, '0);
    pulse(6, 8'h10);
    @(negedge clk); rst_n = 1'b0;
    settle(2);
    rst_n = 1'b1;
    settle(5);
    act_is("R1 after reset", 0, 6);
    chk("R1 lockup after reset", int'(lockup), 0);
    chk("R5 queue drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule